// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit executes one set-vector-length instruction against a 64-bit vector state word. It takes the 32-bit instruction word, the value of the register named by the instruction's source field, the loop-count register value and the current state word. From these it computes the next state word, an optional result for the destination register and an illegal-instruction flag. The new length is always the smaller of the requested length and the maximum length. Three instruction bits choose what is rewritten: the maximum length, the length, and the vertical-first mode bit.

Transactions enter on a valid/ready input channel and leave, one cycle later, from a single output register stage on a valid/ready output channel. An input is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. Once `out_valid` is high, the output payload holds steady until `out_ready` is seen high. Register file access, element stepping and remap shape handling are left to the surrounding pipeline.

Bit positions below are LSB-0. State word: maxvl [63:57], vl [56:50], srcstep [49:43], dststep [42:36], destination substep [35:34], source substep [33:32], remap-persistence [1], vertical-first [0]. Instruction word: destination field RT [25:21], source field RA [20:16], immediate [15:9], set-max bit [8], set-length bit [7], vertical-first bit [6].

Top module: `svl_unit`

## Requirements
- R1: The instruction fields are taken from the positions listed above. The set-max bit is [8], the set-length bit is [7], the vertical-first bit is [6], the 7-bit immediate is [15:9], RA is [20:16] and RT is [25:21].
- R2: When the set-length bit is 1, the new vl is min(request, new maxvl), compared at full register width. When only the set-max bit is 1, the new vl is min(old vl, new maxvl).
- R3: The request is chosen as follows. A non-zero RA field selects `in_ra_val`. A zero RA field with the set-max bit 1 selects the immediate. A zero RA field with the set-max bit 0 selects `in_ctr_val`. The test is on the field value, not on register contents.
- R4: When the set-max bit is 1, maxvl is loaded from the immediate. Otherwise maxvl keeps its old value.
- R5: When the set-max or set-length bit is 1, remap-persistence (state bit [1]) is cleared. Otherwise it is kept.
- R6: When the set-max or set-length bit is 1, the step and substep fields (state bits [49:32]) are cleared. Otherwise they are kept.
- R7: `out_illegal` is 1 in two cases: the set-max bit is 1 and the immediate exceeds 64, or a length update produces a vl above 64. When it is 1, the state word passes through unchanged and `out_result_we` is 0.
- R8: When the instruction is legal, state bit [0] takes the instruction's vertical-first bit.
- R9: State bits [31:2] always pass through unchanged.
- R10: `out_result_we` is 1 exactly when RT is non-zero and the instruction is legal. `out_result` is then the new vl, zero-extended.
- R11: `in_ready` equals `!out_valid || out_ready`. An accepted input appears on the next cycle. A stalled output holds all of its payload.
- R12: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can take an input |
| in_inst | input | 32 | Instruction word |
| in_ra_val | input | XLEN | Value of register named by RA |
| in_ctr_val | input | XLEN | Loop-count register value |
| in_state | input | 64 | Current vector state word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_state | output | 64 | Next vector state word |
| out_result | output | XLEN | Value for destination register |
| out_result_we | output | 1 | Destination write enable |
| out_illegal | output | 1 | Illegal-instruction flag |

## Verification
The hardest case to reach is the illegal path where only the length is updated: maxvl is left above 64 by an earlier direct state write, and a large request clamps to that value. Random stimulus alone seldom meets it, so the directed phase builds incoming state words whose maxvl is 65 to 127 and sweeps every combination of the three mode bits, a zero and non-zero RA, and immediates at 0, 63, 64 and 65. Random back-pressure on `out_ready` holds results in the output stage so that their stability can be checked across stalls.

// File: rtl/svl_pkg.sv
package svl_pkg;
  localparam int STATE_W     = 64;
  localparam int INST_W      = 32;
  localparam int LEN_W       = 7;
  localparam int REG_W       = 5;

  localparam int MAXVL_LSB   = 57;
  localparam int VL_LSB      = 50;
  localparam int STEP_HI     = 49;
  localparam int STEP_LO     = 32;
  localparam int RMPST_BIT   = 1;
  localparam int VFIRST_BIT  = 0;

  localparam int RT_LSB      = 21;
  localparam int RA_LSB      = 16;
  localparam int IMM_LSB     = 9;
  localparam int SETMAX_BIT  = 8;
  localparam int SETLEN_BIT  = 7;
  localparam int VMODE_BIT   = 6;

  typedef struct packed {
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] ra;
    logic [LEN_W-1:0] imm;
    logic             set_max;
    logic             set_len;
    logic             vmode;
  } svl_fields_t;
endpackage

// File: rtl/svl_decode.sv
module svl_decode
  import svl_pkg::*;
(
  input  logic [INST_W-1:0] inst,
  output svl_fields_t       fields
);
  always_comb begin
    fields.rt      = inst[RT_LSB +: REG_W];
    fields.ra      = inst[RA_LSB +: REG_W];
    fields.imm     = inst[IMM_LSB +: LEN_W];
    fields.set_max = inst[SETMAX_BIT];
    fields.set_len = inst[SETLEN_BIT];
    fields.vmode   = inst[VMODE_BIT];
  end
endmodule

// File: rtl/svl_len_calc.sv
module svl_len_calc
  import svl_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int LEN_LIMIT = 64
) (
  input  svl_fields_t      fields,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  input  logic [LEN_W-1:0] cur_maxvl,
  input  logic [LEN_W-1:0] cur_vl,
  output logic [LEN_W-1:0] new_maxvl,
  output logic [LEN_W-1:0] new_vl,
  output logic             len_upd,
  output logic             illegal
);
  localparam logic [LEN_W-1:0] LIMIT_V = LEN_W'(LEN_LIMIT);

  logic [XLEN-1:0]  request;
  logic [LEN_W-1:0] req_clamp;
  logic [LEN_W-1:0] old_clamp;

  always_comb begin
    if (fields.ra != '0)       request = ra_val;
    else if (fields.set_max)   request = XLEN'(fields.imm);
    else                       request = ctr_val;
  end

  assign new_maxvl = fields.set_max ? fields.imm : cur_maxvl;
  assign req_clamp = (request < XLEN'(new_maxvl)) ? request[LEN_W-1:0] : new_maxvl;
  assign old_clamp = (cur_vl < new_maxvl) ? cur_vl : new_maxvl;
  assign len_upd   = fields.set_max | fields.set_len;

  always_comb begin
    if (fields.set_len)      new_vl = req_clamp;
    else if (fields.set_max) new_vl = old_clamp;
    else                     new_vl = cur_vl;
  end

  assign illegal = (fields.set_max && (new_maxvl > LIMIT_V)) ||
                   (len_upd && (new_vl > LIMIT_V));
endmodule

// File: rtl/svl_state_merge.sv
module svl_state_merge
  import svl_pkg::*;
(
  input  logic [STATE_W-1:0] cur_state,
  input  logic [LEN_W-1:0]   new_maxvl,
  input  logic [LEN_W-1:0]   new_vl,
  input  logic               len_upd,
  input  logic               vmode,
  input  logic               illegal,
  output logic [STATE_W-1:0] next_state
);
  always_comb begin
    next_state = cur_state;
    if (!illegal) begin
      if (len_upd) begin
        next_state[MAXVL_LSB +: LEN_W] = new_maxvl;
        next_state[VL_LSB +: LEN_W]    = new_vl;
        next_state[STEP_HI:STEP_LO]    = '0;
        next_state[RMPST_BIT]          = 1'b0;
      end
      next_state[VFIRST_BIT] = vmode;
    end
  end
endmodule

// File: rtl/svl_unit.sv
module svl_unit
  import svl_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int LEN_LIMIT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INST_W-1:0]  in_inst,
  input  logic [XLEN-1:0]    in_ra_val,
  input  logic [XLEN-1:0]    in_ctr_val,
  input  logic [STATE_W-1:0] in_state,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [STATE_W-1:0] out_state,
  output logic [XLEN-1:0]    out_result,
  output logic               out_result_we,
  output logic               out_illegal
);
  localparam int PAD_W = XLEN - LEN_W;

  svl_fields_t        fields;
  logic [LEN_W-1:0]   new_maxvl;
  logic [LEN_W-1:0]   new_vl;
  logic               len_upd;
  logic               illegal;
  logic [STATE_W-1:0] next_state;

  svl_decode u_decode (
    .inst   (in_inst),
    .fields (fields)
  );

  svl_len_calc #(.XLEN(XLEN), .LEN_LIMIT(LEN_LIMIT)) u_len (
    .fields    (fields),
    .ra_val    (in_ra_val),
    .ctr_val   (in_ctr_val),
    .cur_maxvl (in_state[MAXVL_LSB +: LEN_W]),
    .cur_vl    (in_state[VL_LSB +: LEN_W]),
    .new_maxvl (new_maxvl),
    .new_vl    (new_vl),
    .len_upd   (len_upd),
    .illegal   (illegal)
  );

  svl_state_merge u_merge (
    .cur_state  (in_state),
    .new_maxvl  (new_maxvl),
    .new_vl     (new_vl),
    .len_upd    (len_upd),
    .vmode      (fields.vmode),
    .illegal    (illegal),
    .next_state (next_state)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_state     <= '0;
      out_result    <= '0;
      out_result_we <= 1'b0;
      out_illegal   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_state     <= next_state;
        out_result    <= {{PAD_W{1'b0}}, new_vl};
        out_result_we <= (fields.rt != '0) && !illegal;
        out_illegal   <= illegal;
      end
    end
  end
endmodule

// File: rtl/svl_unit_chk.sv
module svl_unit_chk
  import svl_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int LEN_LIMIT = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [STATE_W-1:0] out_state,
  input logic [XLEN-1:0]    out_result,
  input logic               out_result_we,
  input logic               out_illegal
);
  assert_reset_R12: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_state) && $stable(out_result)
      && $stable(out_result_we) && $stable(out_illegal));

  assert_empty_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_result_we);

  assert_result_vl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_result_we |-> out_result == XLEN'(out_state[VL_LSB +: LEN_W]));
endmodule

bind svl_unit svl_unit_chk #(.XLEN(XLEN), .LEN_LIMIT(LEN_LIMIT)) chk_i (.*);

// File: tb/svl_unit_tb_top.sv
`timescale 1ns/1ps
module svl_unit_tb_top;
  localparam int XLEN  = 64;
  localparam int TOTAL = 560;

  typedef struct {
    logic [63:0]     st;
    logic [XLEN-1:0] res;
    logic            we;
    logic            ill;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     in_inst = '0;
  logic [XLEN-1:0] in_ra_val = '0;
  logic [XLEN-1:0] in_ctr_val = '0;
  logic [63:0]     in_state = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [63:0]     out_state;
  logic [XLEN-1:0] out_result;
  logic            out_result_we;
  logic            out_illegal;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  svl_unit #(.XLEN(XLEN), .LEN_LIMIT(64)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model, MSB-0 field view of the instruction.
  function automatic exp_t model(logic [31:0] ins, logic [XLEN-1:0] ra_v,
                                 logic [XLEN-1:0] ctr_v, logic [63:0] st);
    exp_t e;
    bit ms = ins[31-23];
    bit vs = ins[31-24];
    bit vf = ins[31-25];
    int ra = int'(ins[20:16]);
    int rt = int'(ins[25:21]);
    int imm = int'(ins[15:9]);
    int mvl = ms ? imm : int'(st[63:57]);
    int vl = int'(st[56:50]);
    longint unsigned req;
    bit upd = ms || vs;
    if (vs) begin
      req = (ra != 0) ? ra_v : (ms ? longint'(imm) : ctr_v);
      vl = (req < longint'(mvl)) ? int'(req) : mvl;
    end else if (ms) begin
      vl = (vl < mvl) ? vl : mvl;
    end
    e.ill = (ms && mvl > 64) || (upd && vl > 64);
    e.st = st;
    e.res = XLEN'(vl);
    e.we = (rt != 0) && !e.ill;
    if (!e.ill) begin
      if (upd) begin
        e.st[63:57] = 7'(mvl);
        e.st[56:50] = 7'(vl);
        e.st[49:32] = '0;
        e.st[1] = 1'b0;
      end
      e.st[0] = vf;
    end
    return e;
  endfunction

  function automatic logic [63:0] pick_val();
    case ($urandom % 4)
      0: return 64'($urandom % 140);
      1: return {$urandom, $urandom};
      2: return 64'(60 + $urandom % 10);
      default: return 64'(1) << ($urandom % 64);
    endcase
  endfunction

  task automatic gen(input int idx);
    logic [63:0] st = {$urandom, $urandom};
    logic [31:0] ins = $urandom;
    if (idx < 256) begin
      // R1 R3 R4 R5 R6 R7 R8: sweep mode bits, RA zero/non-zero, RT, immediates near 64
      ins[8] = idx[0];
      ins[7] = idx[1];
      ins[6] = idx[2];
      if (!idx[3]) ins[20:16] = '0;
      else if (ins[20:16] == 0) ins[20:16] = 5'd3;
      if (!idx[4]) ins[25:21] = '0;
      else if (ins[25:21] == 0) ins[25:21] = 5'd7;
      case (idx[6:5])
        2'd0: ins[15:9] = 7'd0;
        2'd1: ins[15:9] = 7'd63;
        2'd2: ins[15:9] = 7'd64;
        default: ins[15:9] = 7'd65;
      endcase
      // R7: old maxvl above 64 half the time
      st[63:57] = idx[7] ? 7'(65 + $urandom % 63) : 7'($urandom % 65);
      st[1] = 1'b1;
    end
    in_inst    = ins;
    in_ra_val  = pick_val();
    in_ctr_val = pick_val();
    in_state   = st;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int sent = 0;
    int got = 0;
    bit accepted = 0;
    bit hold = 0;
    logic [63:0] h_st;
    logic [XLEN-1:0] h_res;
    logic h_we, h_ill;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    while (got < TOTAL) begin
      @(negedge clk);
      if (!in_valid || accepted) begin
        if (sent < TOTAL) begin
          gen(sent);
          in_valid = 1'b1;
          sent++;
        end else in_valid = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      chk(in_ready == (!out_valid || out_ready), "R11 in_ready", 64'(in_ready),
          64'(!out_valid || out_ready));
      if (hold) begin
        chk(out_valid && out_state == h_st && out_result == h_res && out_result_we == h_we
            && out_illegal == h_ill, "R11 stalled output held", out_state, h_st);
        hold = 0;
      end
      if (out_valid && out_ready) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected output", 64'd1, 64'd0);
        end else begin
          e = exp_q.pop_front();
          chk(out_illegal == e.ill, "R7 illegal", 64'(out_illegal), 64'(e.ill));
          chk(out_state[56:50] == e.st[56:50], "R2_R3 vl", 64'(out_state[56:50]), 64'(e.st[56:50]));
          chk(out_state[63:57] == e.st[63:57], "R4 maxvl", 64'(out_state[63:57]), 64'(e.st[63:57]));
          chk(out_state[1] == e.st[1], "R5 remap persistence", 64'(out_state[1]), 64'(e.st[1]));
          chk(out_state[49:32] == e.st[49:32], "R6 steps", 64'(out_state[49:32]), 64'(e.st[49:32]));
          chk(out_state[0] == e.st[0], "R1_R8 vertical-first", 64'(out_state[0]), 64'(e.st[0]));
          chk(out_state[31:2] == e.st[31:2], "R9 pass-through", 64'(out_state[31:2]), 64'(e.st[31:2]));
          chk(out_result_we == e.we, "R10 result enable", 64'(out_result_we), 64'(e.we));
          if (e.we) chk(out_result == e.res, "R10 result value", out_result, e.res);
        end
        got++;
      end else if (out_valid) begin
        hold = 1;
        h_st = out_state; h_res = out_result; h_we = out_result_we; h_ill = out_illegal;
      end
      accepted = in_valid && in_ready;
      if (accepted) exp_q.push_back(model(in_inst, in_ra_val, in_ctr_val, in_state));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule